// File: doc/BRIEF.md
# Bit-Addressable I/O Register Space

This block is the I/O register file and address decoder of a small 8-bit CPU. It answers on two ports that reach the same registers. The direct I/O port takes 6-bit addresses. The data-space port takes wide addresses and sees every I/O register at its I/O address plus 0x20. A third path carries single-bit operations: set, clear and test. These are accepted only in the lower half of the I/O space.

The space holds three 8-bit general-purpose registers and one status register with four flags. Each flag is raised by its own hardware event input and is cleared by writing a one to it. A single-bit set or clear changes only the addressed bit. It never writes ones back to the other pending flags in the same register, so a bit operation cannot clear those flags by accident. Reserved and unmapped locations read as zero and ignore writes.

Top module: `io_space`

## Requirements
- R1: On the I/O port, the general-purpose registers sit at 0x13, 0x14 and 0x15 and the status register at 0x1A. Reads are combinational. A write takes effect at the clock edge that samples it and is readable directly after that edge.
- R2: On the data-space port, each register appears at its I/O address plus 0x20. An address outside 0x20 to 0x5F does not hit: `ds_hit_o` is 0, the read returns 0 and a write changes nothing.
- R3: The three general-purpose registers reset to zero and store all 8 bits as written.
- R4: Reserved I/O addresses read as zero and ignore writes. Status bits 7:4 always read zero.
- R5: A bit operation is accepted only for I/O addresses 0x00 to 0x1F. At any higher address, set and clear have no effect and the test result is 0.
- R6: On a general-purpose register, a bit set (`bit_op_i`=1) or bit clear (`bit_op_i`=2) changes only the bit selected by `bit_idx_i`.
- R7: A byte write to the status register clears every flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R8: A bit set on the status register clears only the addressed flag. A bit clear on the status register has no effect.
- R9: An event input `evt_i[k]` raises flag k at the next edge. An event takes priority over a clear in the same cycle.
- R10: A bit test (`bit_op_i`=3) returns on `bit_res_o` the selected bit of the addressed register, combinationally. It returns 0 for reserved locations.
- R11: When several paths write the same register in one cycle, the I/O port wins over the data-space port, and the data-space port wins over a bit operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_addr_i | input | 6 | I/O port address |
| io_we_i | input | 1 | I/O port write enable |
| io_wdata_i | input | 8 | I/O port write data |
| io_rdata_o | output | 8 | I/O port read data |
| ds_addr_i | input | 16 | Data-space address |
| ds_we_i | input | 1 | Data-space write enable |
| ds_wdata_i | input | 8 | Data-space write data |
| ds_rdata_o | output | 8 | Data-space read data |
| ds_hit_o | output | 1 | Data-space address lies in the I/O window |
| bit_addr_i | input | 6 | I/O address of a bit operation |
| bit_idx_i | input | 3 | Bit position of a bit operation |
| bit_op_i | input | 2 | 0 none, 1 set, 2 clear, 3 test |
| bit_res_o | output | 1 | Bit test result |
| evt_i | input | 4 | Hardware events that raise the status flags |

## Verification
Reads and the bit-test result are combinational, so the bench checks them 1 ns after it applies an address, with no clock edge in between. Writes, bit set and clear, and events are driven at a falling edge and captured at the next rising edge. The bench reads the result back at the falling edge that follows, one cycle after the stimulus. Tests of ignored accesses read the affected registers back through the I/O port in that same cycle.

// File: rtl/io_space_pkg.sv
package io_space_pkg;
  localparam int DW        = 8;
  localparam int IO_AW     = 6;
  localparam int BIT_AW    = 5;
  localparam int DS_AW     = 16;
  localparam int DS_OFFSET = 32;
  localparam int NUM_GP    = 3;
  localparam int NUM_FLAGS = 4;
  localparam int NREG      = NUM_GP + 1;
  localparam int FLAG_SLOT = NUM_GP;

  localparam logic [IO_AW-1:0] GP_BASE   = 6'h13;
  localparam logic [IO_AW-1:0] FLAG_ADDR = 6'h1A;

  typedef enum logic [1:0] {
    BOP_NONE = 2'd0,
    BOP_SET  = 2'd1,
    BOP_CLR  = 2'd2,
    BOP_TEST = 2'd3
  } bit_op_e;
endpackage

// File: rtl/io_addr_dec.sv
module io_addr_dec
  import io_space_pkg::*;
(
  input  logic [IO_AW-1:0] addr_i,
  output logic [NREG-1:0]  sel_o
);
  for (genvar k = 0; k < NUM_GP; k++) begin : g_gp_sel
    assign sel_o[k] = (addr_i == IO_AW'(GP_BASE + k));
  end
  assign sel_o[FLAG_SLOT] = (addr_i == FLAG_ADDR);
endmodule

// File: rtl/io_gp_reg.sv
module io_gp_reg #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
    else           q_o <= (q_o | set_i) & ~clr_i;
  end

  // R6: a single-bit op must not disturb unmasked bits
  assert_bitop_isolated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i) |=> ((q_o ^ $past(q_o)) & ~$past(set_i | clr_i)) == '0);

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && set_i == '0 && clr_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/io_flag_reg.sv
module io_flag_reg #(
  parameter int NF = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] clr_i,
  input  logic [NF-1:0] evt_i,
  output logic [NF-1:0] q_o
);
  // events win over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | evt_i;
  end

  assert_evt_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> (q_o & $past(evt_i)) == $past(evt_i));

  assert_w1c_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~evt_i) != '0) |=> (q_o & $past(clr_i & ~evt_i)) == '0);

  assert_no_spurious_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (q_o & ~$past(q_o) & ~$past(evt_i)) == '0);
endmodule

// File: rtl/io_space.sv
module io_space
  import io_space_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic             io_we_i,
  input  logic [DW-1:0]    io_wdata_i,
  output logic [DW-1:0]    io_rdata_o,
  input  logic [DS_AW-1:0] ds_addr_i,
  input  logic             ds_we_i,
  input  logic [DW-1:0]    ds_wdata_i,
  output logic [DW-1:0]    ds_rdata_o,
  output logic             ds_hit_o,
  input  logic [IO_AW-1:0] bit_addr_i,
  input  logic [2:0]       bit_idx_i,
  input  logic [1:0]       bit_op_i,
  output logic             bit_res_o,
  input  logic [NUM_FLAGS-1:0] evt_i
);
  localparam logic [DS_AW-1:0] DS_LO = DS_AW'(DS_OFFSET);
  localparam logic [DS_AW-1:0] DS_HI = DS_AW'(DS_OFFSET + 2**IO_AW);

  bit_op_e          bop;
  logic [IO_AW-1:0] ds_io_addr, bit_io_addr;
  logic [NREG-1:0]  io_sel, ds_sel, bit_sel;
  logic             bit_ok;
  logic [DW-1:0]    bit_mask;
  logic [NREG-1:0][DW-1:0] regs;
  logic [NREG-1:0]  full_we;
  logic [DW-1:0]    full_data [NREG];
  logic [DW-1:0]    set_m [NREG];
  logic [DW-1:0]    clr_m [NREG];
  logic [NUM_FLAGS-1:0] flag_q, flag_clr;

  assign bop         = bit_op_e'(bit_op_i);
  assign ds_hit_o    = (ds_addr_i >= DS_LO) && (ds_addr_i < DS_HI);
  assign ds_io_addr  = IO_AW'(ds_addr_i - DS_LO);
  assign bit_ok      = (bit_addr_i[IO_AW-1:BIT_AW] == '0);
  // low bits only: the range gate, not the decoder, rejects high addresses
  assign bit_io_addr = IO_AW'(bit_addr_i[BIT_AW-1:0]);
  assign bit_mask    = DW'(1) << bit_idx_i;

  io_addr_dec u_dec_io  (.addr_i(io_addr_i),   .sel_o(io_sel));
  io_addr_dec u_dec_ds  (.addr_i(ds_io_addr),  .sel_o(ds_sel));
  io_addr_dec u_dec_bit (.addr_i(bit_io_addr), .sel_o(bit_sel));

  always_comb begin
    for (int k = 0; k < NREG; k++) begin
      logic io_w, ds_w, bit_w;
      io_w  = io_we_i && io_sel[k];
      ds_w  = ds_we_i && ds_hit_o && ds_sel[k];
      bit_w = bit_ok && bit_sel[k] && !io_w && !ds_w;
      full_we[k]   = io_w || ds_w;
      full_data[k] = io_w ? io_wdata_i : ds_wdata_i;
      set_m[k]     = (bit_w && bop == BOP_SET) ? bit_mask : '0;
      clr_m[k]     = (bit_w && bop == BOP_CLR) ? bit_mask : '0;
    end
  end

  for (genvar k = 0; k < NUM_GP; k++) begin : g_gp
    io_gp_reg #(.DW(DW)) u_gp (
      .clk_i, .rst_ni,
      .we_i(full_we[k]), .wdata_i(full_data[k]),
      .set_i(set_m[k]), .clr_i(clr_m[k]),
      .q_o(regs[k])
    );
  end

  // a one written, by byte or by bit set, clears; bit clear writes zero: no-op
  assign flag_clr = full_we[FLAG_SLOT] ? full_data[FLAG_SLOT][NUM_FLAGS-1:0]
                                       : set_m[FLAG_SLOT][NUM_FLAGS-1:0];

  io_flag_reg #(.NF(NUM_FLAGS)) u_flags (
    .clk_i, .rst_ni, .clr_i(flag_clr), .evt_i(evt_i), .q_o(flag_q)
  );
  assign regs[FLAG_SLOT] = DW'(flag_q);

  function automatic logic [DW-1:0] rd_mux(input logic [NREG-1:0] sel,
                                           input logic [NREG-1:0][DW-1:0] r);
    logic [DW-1:0] v;
    v = '0;
    for (int k = 0; k < NREG; k++) if (sel[k]) v |= r[k];
    return v;
  endfunction

  logic [DW-1:0] bit_byte;
  assign io_rdata_o = rd_mux(io_sel, regs);
  assign ds_rdata_o = ds_hit_o ? rd_mux(ds_sel, regs) : '0;
  assign bit_byte   = rd_mux(bit_sel, regs);
  assign bit_res_o  = (bop == BOP_TEST) && bit_ok && bit_byte[bit_idx_i];

  assert_dec_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(io_sel) && $onehot0(ds_sel) && $onehot0(bit_sel));

  assert_ds_miss_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ds_hit_o |-> ds_rdata_o == '0);

  assert_bit_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_ok |-> !bit_res_o);

  assert_reserved_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_we_i && io_sel == '0 && !ds_we_i && bop == BOP_NONE && evt_i == '0)
      |=> $stable(regs));

  assert_status_upper_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_sel[FLAG_SLOT] |-> io_rdata_o[DW-1:NUM_FLAGS] == '0);
endmodule

// File: tb/io_space_test.sv
module io_space_test;
  logic       clk = 0, rst_n = 0;
  logic [5:0] io_addr = 0, bit_addr = 0;
  logic       io_we = 0, ds_we = 0, bit_res, ds_hit;
  logic [7:0] io_wdata = 0, io_rdata, ds_wdata = 0, ds_rdata;
  logic [15:0] ds_addr = 0;
  logic [2:0] bit_idx = 0;
  logic [1:0] bit_op = 0;
  logic [3:0] evt = 0;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  io_space uut (
    .clk_i(clk), .rst_ni(rst_n),
    .io_addr_i(io_addr), .io_we_i(io_we), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .ds_addr_i(ds_addr), .ds_we_i(ds_we), .ds_wdata_i(ds_wdata), .ds_rdata_o(ds_rdata),
    .ds_hit_o(ds_hit), .bit_addr_i(bit_addr), .bit_idx_i(bit_idx), .bit_op_i(bit_op),
    .bit_res_o(bit_res), .evt_i(evt)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic io_rd(logic [5:0] a, string tag, logic [7:0] exp);
    io_addr = a; #1; chk(tag, io_rdata, exp);
  endtask

  task automatic io_wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_we = 1;
    @(negedge clk); io_we = 0;
  endtask

  task automatic ds_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); ds_addr = a; ds_wdata = d; ds_we = 1;
    @(negedge clk); ds_we = 0;
  endtask

  task automatic bit_do(logic [5:0] a, logic [2:0] i, logic [1:0] op);
    @(negedge clk); bit_addr = a; bit_idx = i; bit_op = op;
    @(negedge clk); bit_op = 0;
  endtask

  task automatic bit_test(logic [5:0] a, logic [2:0] i, string tag, logic exp);
    bit_addr = a; bit_idx = i; bit_op = 3; #1;
    chk(tag, {7'b0, bit_res}, {7'b0, exp});
    bit_op = 0;
  endtask

  task automatic t_reset;
    for (int k = 0; k < 3; k++) io_rd(6'h13 + 6'(k), "R3 reset value", 8'h00);
    io_rd(6'h1A, "R9 flags reset", 8'h00);
  endtask

  task automatic t_io_rw;
    io_wr(6'h13, 8'hA5); io_wr(6'h14, 8'h3C); io_wr(6'h15, 8'hFF);
    io_rd(6'h13, "R1 gp0 at 0x13", 8'hA5);
    io_rd(6'h14, "R3 gp1 full byte", 8'h3C);
    io_rd(6'h15, "R3 gp2 full byte", 8'hFF);
  endtask

  task automatic t_ds;
    ds_addr = 16'h0033; #1; chk("R2 ds read offset", ds_rdata, 8'hA5);
    chk("R2 ds hit", {7'b0, ds_hit}, 8'h01);
    ds_wr(16'h0034, 8'h11); io_rd(6'h14, "R2 ds write", 8'h11);
    ds_addr = 16'h0013; #1; chk("R2 ds below window", ds_rdata, 8'h00);
    chk("R2 ds miss flag", {7'b0, ds_hit}, 8'h00);
    ds_wr(16'h0074, 8'h77); io_rd(6'h14, "R2 ds write above window", 8'h11);
    ds_wr(16'h0015, 8'h00); io_rd(6'h15, "R2 ds write below window", 8'hFF);
  endtask

  task automatic t_reserved;
    io_wr(6'h00, 8'hFF); io_rd(6'h00, "R4 reserved read", 8'h00);
    io_wr(6'h3F, 8'h5A); io_rd(6'h3F, "R4 reserved high read", 8'h00);
    io_rd(6'h13, "R4 gp0 untouched", 8'hA5);
    io_rd(6'h14, "R4 gp1 untouched", 8'h11);
    io_rd(6'h15, "R4 gp2 untouched", 8'hFF);
  endtask

  task automatic t_bits_gp;
    bit_do(6'h15, 3'd3, 2'd2); io_rd(6'h15, "R6 bit clear gp2", 8'hF7);
    bit_do(6'h13, 3'd1, 2'd1); io_rd(6'h13, "R6 bit set gp0", 8'hA7);
    bit_test(6'h13, 3'd0, "R10 test bit0", 1'b1);
    bit_test(6'h13, 3'd3, "R10 test bit3", 1'b0);
    bit_test(6'h00, 3'd0, "R10 test reserved", 1'b0);
  endtask

  task automatic t_bit_range;
    bit_do(6'h33, 3'd4, 2'd1); io_rd(6'h13, "R5 set above 0x1F ignored", 8'hA7);
    bit_do(6'h35, 3'd0, 2'd2); io_rd(6'h15, "R5 clear above 0x1F ignored", 8'hF7);
    bit_test(6'h33, 3'd0, "R5 test above 0x1F", 1'b0);
  endtask

  task automatic t_flags;
    @(negedge clk); evt = 4'hF; @(negedge clk); evt = 0;
    io_rd(6'h1A, "R9 events raise flags", 8'h0F);
    io_wr(6'h1A, 8'hF5); io_rd(6'h1A, "R7 w1c byte write, R4 upper zero", 8'h0A);
    @(negedge clk); evt = 4'hF; @(negedge clk); evt = 0;
    bit_do(6'h1A, 3'd1, 2'd1); io_rd(6'h1A, "R8 bit set clears one flag", 8'h0D);
    bit_do(6'h1A, 3'd2, 2'd2); io_rd(6'h1A, "R8 bit clear no effect", 8'h0D);
    bit_test(6'h1A, 3'd3, "R10 test flag", 1'b1);
    @(negedge clk); io_addr = 6'h1A; io_wdata = 8'h0D; io_we = 1; evt = 4'h1;
    @(negedge clk); io_we = 0; evt = 0;
    io_rd(6'h1A, "R9 event beats clear", 8'h01);
  endtask

  task automatic t_priority;
    @(negedge clk);
    io_addr = 6'h14; io_wdata = 8'h22; io_we = 1;
    ds_addr = 16'h0034; ds_wdata = 8'h99; ds_we = 1;
    @(negedge clk); io_we = 0; ds_we = 0;
    io_rd(6'h14, "R11 io over ds", 8'h22);
    @(negedge clk);
    ds_addr = 16'h0033; ds_wdata = 8'h55; ds_we = 1;
    bit_addr = 6'h13; bit_idx = 3'd7; bit_op = 2'd1;
    @(negedge clk); ds_we = 0; bit_op = 0;
    io_rd(6'h13, "R11 ds over bit op", 8'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_io_rw; t_ds; t_reserved; t_bits_gp; t_bit_range; t_flags; t_priority;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule